// File: doc/BRIEF.md
# Serial Segment Display Data Receiver

This block takes a serial stream framed by a chip select and turns it into a display image plus a small set of mode bits for a multiplexed segment display sequencer. While the select line is high, each rising edge of the serial clock pushes one data bit into a single shift chain. When the select line falls, the whole chain is copied into shadow registers. From that moment the new image and mode bits drive the sequencer. A frame carries 96 display bits, sent first, and then an 8-bit control field.

All three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the edges are detected in the system clock domain, so the system clock must run several times faster than the serial clock. The shift chain is never cleared by the framing. It always holds the most recent 104 bits, and that is exactly what gets latched.

Top module: `lcdrx_top`

## Requirements
- R1: While `rst_n` is low, `disp_img_o` is all zeros and `bias_half_o`, `low_power_o` and `blank_o` are 0.
- R2: Number the bits of a frame D1..D104 in the order received. When the frame ends, segment s (0-based, 0..31) and common c (1..3) take `disp_img_o[s*3 + c - 1]` = D(3s + 4 - c). So COM3 of segment s gets D(3s+1), COM2 gets D(3s+2) and COM1 gets D(3s+3).
- R3: The outputs keep their previous values while a frame is being shifted in. They change only after `cs_i` falls.
- R4: Serial clock edges seen while `cs_i` is low shift nothing. A later frame with no clock edges re-latches the previous chain contents unchanged.
- R5: If more than 104 bits arrive in one frame, only the last 104 bits received are latched.
- R6: The control field is D97..D104. `bias_half_o` = D102 (1 selects half bias, 0 selects third bias), `low_power_o` = D103 and `blank_o` = D104. The values of D97..D101 have no effect on any output.
- R7: A low pulse on `rst_n` in the middle of a frame also clears the shift chain. A following frame with no clock edges latches all zeros.
- R8: One bit is shifted per rising edge of the serial clock. Falling edges shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Frame select; high while a frame is being sent |
| sck_i | input | 1 | Serial bit clock; data taken on its rising edge |
| sdi_i | input | 1 | Serial data |
| disp_img_o | output | 96 | Latched image, index segment*3 + common - 1 |
| bias_half_o | output | 1 | Latched bias select (1 = half bias) |
| low_power_o | output | 1 | Latched low-power request |
| blank_o | output | 1 | Latched blank-display request |

## Verification
The hardest condition to reach from the ports is a frame that shifts nothing, because that is the only way the retained chain contents become visible. The stimulus creates it twice. First it sends stray serial clocks with select low and then an empty select pulse, which must reproduce the last image. Second it pulses reset mid-frame and then sends an empty frame, which must produce zeros. Overlong frames with random leading junk exercise the window behaviour. Random frames with random filler bits in the control field cover the bit interleave and show that the filler is ignored.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
  // Mode bits taken from the tail of each frame
  typedef struct packed {
    logic bias_half;
    logic low_power;
    logic blank;
  } lcdrx_mode_t;

  localparam int MODE_BITS = 3;
endpackage

// File: rtl/lcdrx_rst_sync.sv
module lcdrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stg_in;
    if (g == 0) begin : g_first
      assign stg_in = d_i;
    end else begin : g_rest
      assign stg_in = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_in;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcdrx_shift.sv
module lcdrx_shift #(
  parameter int WIDTH = 104
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] chain_o
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_nxt;

  // Newest bit enters at index 0; the oldest falls out of the top
  always_comb begin
    chain_nxt = chain_q;
    if (shift_en) chain_nxt = {chain_q[WIDTH-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/lcdrx_top.sv
module lcdrx_top
  import lcdrx_pkg::*;
#(
  parameter int NUM_SEG     = 32,
  parameter int NUM_COM     = 3,
  parameter int CTRL_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_i,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  output logic [NUM_SEG*NUM_COM-1:0] disp_img_o,
  output logic                       bias_half_o,
  output logic                       low_power_o,
  output logic                       blank_o
);
  localparam int IMG_BITS   = NUM_SEG * NUM_COM;
  localparam int FRAME_BITS = IMG_BITS + CTRL_BITS;

  logic rst_sync_n;
  logic cs_s, sck_s, sdi_s;
  logic cs_q, sck_q;
  logic cs_nxt, sck_nxt;
  logic shift_en, latch_en;
  logic [FRAME_BITS-1:0] chain;
  logic [IMG_BITS-1:0]   img_map;
  logic [IMG_BITS-1:0]   img_q, img_nxt;
  lcdrx_mode_t           mode_map, mode_q, mode_nxt;

  lcdrx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lcdrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d_i({cs_i, sck_i, sdi_i}),
    .q_o({cs_s, sck_s, sdi_s})
  );

  // Edge detection in the system clock domain
  always_comb begin
    cs_nxt   = cs_s;
    sck_nxt  = sck_s;
    shift_en = cs_s & sck_s & ~sck_q;
    latch_en = cs_q & ~cs_s;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_nxt;
      sck_q <= sck_nxt;
    end
  end

  lcdrx_shift #(.WIDTH(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_sync_n),
    .shift_en(shift_en), .bit_in(sdi_s),
    .chain_o(chain)
  );

  // Bit k of a frame (1-based, first received) sits at chain[FRAME_BITS-k].
  // Common c (0 = first common) of segment s takes bit NUM_COM*(s+1)-c.
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
      assign img_map[s*NUM_COM + c] = chain[FRAME_BITS - NUM_COM*(s+1) + c];
    end
  end

  // The last three received bits are the mode bits, in this order
  assign mode_map = lcdrx_mode_t'(chain[MODE_BITS-1:0]);

  always_comb begin
    img_nxt  = img_q;
    mode_nxt = mode_q;
    if (latch_en) begin
      img_nxt  = img_map;
      mode_nxt = mode_map;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      img_q  <= '0;
      mode_q <= '0;
    end else begin
      img_q  <= img_nxt;
      mode_q <= mode_nxt;
    end
  end

  assign disp_img_o  = img_q;
  assign bias_half_o = mode_q.bias_half;
  assign low_power_o = mode_q.low_power;
  assign blank_o     = mode_q.blank;
endmodule

// File: rtl/lcdrx_chk.sv
module lcdrx_chk #(
  parameter int FW = 104,
  parameter int IW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          sdi_s,
  input logic          shift_en,
  input logic          latch_en,
  input logic [FW-1:0] chain,
  input logic [IW-1:0] img,
  input logic          bias_half,
  input logic          low_power,
  input logic          blank
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (img == '0 && !bias_half && !low_power && !blank));

  // R3
  img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(img));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> ($stable(bias_half) && $stable(low_power) && $stable(blank)));

  // R4
  idle_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> $stable(chain));

  // R8
  shift_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (chain[0] == $past(sdi_s)));
endmodule

bind lcdrx_top lcdrx_chk #(.FW(FRAME_BITS), .IW(IMG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdi_s(sdi_s),
  .shift_en(shift_en), .latch_en(latch_en), .chain(chain),
  .img(img_q), .bias_half(bias_half_o), .low_power(low_power_o),
  .blank(blank_o)
);

// File: tb/test_lcdrx_top.sv
module test_lcdrx_top;
  localparam int NS = 32;
  localparam int NC = 3;
  localparam int IB = NS * NC;
  localparam int FB = IB + 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cs, sck, sdi;
  logic [IB-1:0] img;
  logic bh, lp, bl;
  int n_run = 0;
  int n_fail = 0;

  lcdrx_top i_lcdrx_top (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .disp_img_o(img), .bias_half_o(bh), .low_power_o(lp), .blank_o(bl)
  );

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  // R8: the bit is held across both clock edges; only the rising one counts
  task automatic put_bit(logic b);
    @(negedge clk); sdi = b;
    wait_clk(4);
    @(negedge clk); sck = 1'b1;
    wait_clk(4);
    @(negedge clk); sck = 1'b0;
    wait_clk(3);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1;
    wait_clk(4);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0;
    wait_clk(10);
  endtask

  task automatic put_frame(logic [1:FB] fr);
    for (int k = 1; k <= FB; k++) put_bit(fr[k]);
  endtask

  task automatic send(logic [1:FB] fr);
    cs_on(); put_frame(fr); cs_off();
  endtask

  function automatic logic [1:FB] rand_frame();
    logic [1:FB] fr;
    for (int k = 1; k <= FB; k++) fr[k] = 1'($urandom_range(0, 1));
    return fr;
  endfunction

  // R2: segment s, common c -> index s*3+c-1 carries bit D(3s+4-c)
  function automatic logic [IB-1:0] exp_img(logic [1:FB] fr);
    logic [IB-1:0] e;
    for (int s = 0; s < NS; s++)
      for (int c = 1; c <= NC; c++)
        e[s*NC + c - 1] = fr[NC*s + NC + 1 - c];
    return e;
  endfunction

  task automatic check(string req, logic [1:FB] fr);
    logic [IB-1:0] ei;
    logic [2:0] em;
    @(negedge clk);
    ei = exp_img(fr);
    em = {fr[102], fr[103], fr[104]};  // R6 mode bit positions
    n_run++;
    if (img !== ei) begin
      n_fail++;
      $display("FAIL %s image: got %h expected %h", req, img, ei);
    end
    n_run++;
    if ({bh, lp, bl} !== em) begin
      n_fail++;
      $display("FAIL %s mode: got %b expected %b", req, {bh, lp, bl}, em);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:FB] zero_fr, fa, fb, fr;
    void'($urandom(32'h5eed_1a7c));
    zero_fr = '0;
    rst_n = 1'b1; cs = 1'b0; sck = 1'b0; sdi = 1'b0;
    #3 rst_n = 1'b0;
    wait_clk(5);
    check("R1 reset", zero_fr);
    @(negedge clk); rst_n = 1'b1;
    wait_clk(6);
    check("R1 after release", zero_fr);

    // R2/R6 directed: all ones, then control filler set with mode bits clear
    fr = '1;
    send(fr); check("R2 all ones", fr);
    fr = '0; fr[97:101] = '1;
    send(fr); check("R6 filler ignored", fr);
    fr = '0; fr[1] = 1'b1; fr[96] = 1'b1; fr[102] = 1'b1;
    send(fr); check("R2 end bits", fr);
    fr = '0; fr[2] = 1'b1; fr[95] = 1'b1; fr[103] = 1'b1;
    send(fr); check("R6 low power", fr);
    fr = '0; fr[50] = 1'b1; fr[104] = 1'b1;
    send(fr); check("R6 blank", fr);

    // R2/R6 random frames, filler bits random too
    for (int i = 0; i < 12; i++) begin
      fr = rand_frame();
      send(fr); check("R2 R6 random", fr);
    end

    // R3: outputs hold mid-frame
    fa = rand_frame(); send(fa);
    fb = rand_frame();
    cs_on();
    for (int k = 1; k <= 60; k++) put_bit(fb[k]);
    wait_clk(10);
    check("R3 mid-frame hold", fa);
    for (int k = 61; k <= FB; k++) put_bit(fb[k]);
    wait_clk(10);
    check("R3 before select falls", fa);
    cs_off();
    check("R3 after select falls", fb);

    // R4: stray clocks with select low, then an empty frame
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); sdi = ~fb[FB - i];
      wait_clk(3);
      @(negedge clk); sck = 1'b1;
      wait_clk(3);
      @(negedge clk); sck = 1'b0;
      wait_clk(3);
    end
    wait_clk(10);
    check("R4 stray clocks", fb);
    cs_on(); cs_off();
    check("R4 empty frame relatch", fb);

    // R5: overlong frames
    for (int i = 0; i < 3; i++) begin
      fr = rand_frame();
      cs_on();
      for (int k = 0; k < 20 + 17 * i; k++) put_bit(1'($urandom_range(0, 1)));
      put_frame(fr);
      cs_off();
      check("R5 overlong", fr);
    end

    // R7: reset mid-frame clears everything, including the chain
    fr = '1; send(fr);
    cs_on();
    for (int k = 1; k <= 40; k++) put_bit(1'b1);
    @(negedge clk); rst_n = 1'b0; cs = 1'b0;
    wait_clk(3);
    check("R7 reset mid-frame", zero_fr);
    @(negedge clk); rst_n = 1'b1;
    wait_clk(6);
    cs_on(); cs_off();
    check("R7 chain cleared", zero_fr);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule